// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting channel of an interval timer. A host supplies a reload value and a 3-bit mode together on one load strobe; from then on the channel counts on every cycle in which its counting clock enable is high, and it drives one output whose waveform depends on the selected mode. It can act as a terminal-count flag, a retriggerable one-shot, a periodic rate generator, a square-wave generator, or a one-count strobe started by software or by the gate input. The current count is shown on a port all the time, so a latch stage outside the block can sample it.

The gate input has two roles. In the flag and software-strobe modes it acts as a level enable. In the one-shot, rate, square-wave and hardware-strobe modes a rising edge restarts the period from the stored reload value. A reload value of zero stands for 65536 counts. The count is a plain 16-bit binary value.

Top module: `tmr_channel`

## Requirements
- R1: After reset the channel is in square-wave mode with reload 65536: out is 1 and count reads 0. The stored previous gate level starts at 1 for channel indices 0 and 1 and at 0 for index 2, so a gate held high through reset on channel 0 gives no restart edge.
- R2: A load strobe takes priority over gate edges and count ticks. It stores the value and the mode and restarts the period. A value of 0 means 65536. In every mode except square wave, count reads the loaded value on the cycle after the strobe.
- R3: Mode 0 (terminal flag): out goes to 0 on load. It becomes 1 on the tick that brings the count to 0, and it stays 1 until the next load.
- R4: Mode 1 (one-shot): after a load, out is 1 and the count holds until a gate rising edge. That edge reloads the count and drives out to 0. Out returns to 1 on the tick that brings the count to 0.
- R5: Mode 2 (rate): out is 1 except for one tick-interval at 0 after every N ticks. On that same tick the count reloads to N. There is no pulse at time zero.
- R6: Mode 3 (square wave, for N ≥ 2): out is 1 for (N+1)/2 ticks and 0 for N/2 ticks in each period. The count steps down by 2 per tick and always reads even.
- R7: Mode 4 (software strobe): out is 1 after load. It is 0 for exactly the one tick-interval that starts when the count first reaches 0, and it makes no further transitions until a new load.
- R8: Mode 5 (hardware strobe): like mode 4, but counting starts only on a gate rising edge. Each rising edge re-arms the strobe.
- R9: A gate rising edge in modes 1, 2, 3 and 5 restarts the period from the stored reload value, with out returning to its start-of-period level.
- R10: In modes 0 and 4 a low gate suspends counting (count and out hold). Gate edges do not restart in these modes.
- R11: In modes 0, 1, 4 and 5 the count keeps decrementing and wraps modulo 65536 after the terminal count.
- R12: On cycles with the counting clock enable low, neither count nor out changes, unless a load or a gate restart occurs.
- R13: Mode codes 6 and 7 behave as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting clock enable, one tick per high cycle |
| gate | input | 1 | Gate: level enable or rising-edge restart, depending on mode |
| load_stb | input | 1 | Load strobe for reload value and mode |
| load_val | input | 16 | Reload value, 0 means 65536 |
| mode_sel | input | 3 | Mode code 0 to 7 |
| out | output | 1 | Channel output waveform |
| count | output | 16 | Current count |

## Verification
The bench builds the channel with the default 16-bit width and channel index 0. With the full width, a load of 0 can be run all the way to its terminal count after 65536 ticks and then past the wrap, all inside the cycle budget. Index 0 makes the gate memory start high, so the first ticks after reset show whether a restart was wrongly seen. Expected out and count values come from closed-form functions of the number of ticks since the last load or restart, and they are compared on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        M_TERM    = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5
    } tmr_mode_e;

    // codes 6 and 7 alias the rate and square modes
    function automatic tmr_mode_e fold_mode(input logic [2:0] code);
        if (code[2:1] == 2'b11) begin
            return tmr_mode_e'({1'b0, code[1:0]});
        end
        return tmr_mode_e'(code);
    endfunction

    function automatic logic gate_is_level(input tmr_mode_e m);
        return (m == M_TERM) || (m == M_SWSTB);
    endfunction

endpackage

// File: rtl/tmr_gate_ctl.sv
module tmr_gate_ctl
    import tmr_pkg::*;
#(
    parameter bit GATE_INIT = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cnt_en,
    input  logic      gate,
    input  tmr_mode_e mode,
    output logic      tick,
    output logic      gate_rise
);

    typedef struct packed {
        logic gate_prev;
    } gctl_t;

    gctl_t st_d, st_q;
    logic  level_mode;

    always_comb begin
        st_d           = st_q;
        st_d.gate_prev = gate;
        level_mode     = gate_is_level(mode);
        tick           = cnt_en & (gate | ~level_mode);
        gate_rise      = gate & ~st_q.gate_prev & ~level_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{gate_prev: GATE_INIT};
        end else begin
            st_q <= st_d;
        end
    end

    // R9: an edge is reported for a single cycle only
    p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gate_rise |=> !gate_rise);

endmodule

// File: rtl/tmr_reload.sv
module tmr_reload
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] reload_val,
    input  tmr_mode_e    mode,
    output logic [W-1:0] start_val,
    output logic [W-1:0] low_val
);

    logic [W-1:0] even_up;
    logic [W-1:0] even_dn;

    always_comb begin
        // odd periods: the high half gets the extra count
        even_up   = reload_val + W'(reload_val[0]);
        even_dn   = {reload_val[W-1:1], 1'b0};
        start_val = (mode == M_SQUARE) ? even_up : reload_val;
        low_val   = even_dn;
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_stb,
    input  logic [W-1:0] load_val,
    input  logic [2:0]   load_mode,
    input  logic         tick,
    input  logic         gate_rise,
    input  logic [W-1:0] start_val,
    input  logic [W-1:0] low_val,
    output logic [W-1:0] calc_val,
    output tmr_mode_e    calc_mode,
    output logic [W-1:0] count_o,
    output logic         out_o,
    output tmr_mode_e    mode_o
);

    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    typedef struct packed {
        logic [W-1:0] count;
        logic [W-1:0] reload;
        tmr_mode_e    mode;
        logic         out;
        logic         run;
        logic         fired;
    } core_t;

    core_t st_d, st_q;

    assign calc_val  = load_stb ? load_val : st_q.reload;
    assign calc_mode = load_stb ? fold_mode(load_mode) : st_q.mode;

    always_comb begin
        st_d = st_q;
        if (load_stb) begin
            st_d.mode   = fold_mode(load_mode);
            st_d.reload = load_val;
            st_d.count  = start_val;
            st_d.fired  = 1'b0;
            unique case (fold_mode(load_mode))
                M_TERM: begin
                    st_d.out = 1'b0;
                    st_d.run = 1'b1;
                end
                M_ONESHOT, M_HWSTB: begin
                    st_d.out = 1'b1;
                    st_d.run = 1'b0;
                end
                default: begin
                    st_d.out = 1'b1;
                    st_d.run = 1'b1;
                end
            endcase
        end else if (gate_rise) begin
            st_d.count = start_val;
            st_d.fired = 1'b0;
            st_d.run   = 1'b1;
            st_d.out   = (st_q.mode != M_ONESHOT);
        end else if (tick && st_q.run) begin
            unique case (st_q.mode)
                M_TERM, M_ONESHOT: begin
                    st_d.count = st_q.count - ONE;
                    if (st_q.count == ONE) begin
                        st_d.out = 1'b1;
                    end
                end
                M_RATE: begin
                    if (st_q.count == ONE) begin
                        st_d.count = st_q.reload;
                        st_d.out   = 1'b0;
                    end else begin
                        st_d.count = st_q.count - ONE;
                        st_d.out   = 1'b1;
                    end
                end
                M_SQUARE: begin
                    if (st_q.count == TWO) begin
                        st_d.out   = ~st_q.out;
                        st_d.count = st_q.out ? low_val : start_val;
                    end else begin
                        st_d.count = st_q.count - TWO;
                    end
                end
                default: begin
                    st_d.count = st_q.count - ONE;
                    st_d.out   = !((st_q.count == ONE) && !st_q.fired);
                    if (st_q.count == ONE) begin
                        st_d.fired = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{count: '0, reload: '0, mode: M_SQUARE,
                      out: 1'b1, run: 1'b1, fired: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign out_o   = st_q.out;
    assign mode_o  = st_q.mode;

    // R3: flag stays set until the next load
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_TERM && st_q.out && !load_stb) |=> st_q.out);

    // R4: waiting one-shot keeps out high
    p_oneshot_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_ONESHOT && !st_q.run) |-> st_q.out);

    // R5: rate pulse lasts one tick when N is not 1
    p_rate_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RATE && !st_q.out && st_q.reload != ONE &&
         tick && !load_stb && !gate_rise) |=> st_q.out);

    // R6: square-wave count is always even
    p_square_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_SQUARE) |-> !st_q.count[0]);

    // R7: strobe low for one tick interval
    p_strobe_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == M_SWSTB || st_q.mode == M_HWSTB) && !st_q.out &&
         tick && !load_stb && !gate_rise) |=> st_q.out);

    // R12: no tick, no load, no restart -> nothing moves
    p_hold_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_stb && !gate_rise && !tick) |=>
            ($stable(st_q.count) && $stable(st_q.out)));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W          = 16,
    parameter int CHAN_INDEX = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         gate,
    input  logic         load_stb,
    input  logic [W-1:0] load_val,
    input  logic [2:0]   mode_sel,
    output logic         out,
    output logic [W-1:0] count
);

    localparam bit GATE_INIT = (CHAN_INDEX != 2);

    logic         tick;
    logic         gate_rise;
    logic [W-1:0] calc_val;
    tmr_mode_e    calc_mode;
    logic [W-1:0] start_val;
    logic [W-1:0] low_val;
    tmr_mode_e    cur_mode;

    tmr_gate_ctl #(.GATE_INIT(GATE_INIT)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .gate      (gate),
        .mode      (cur_mode),
        .tick      (tick),
        .gate_rise (gate_rise)
    );

    tmr_reload #(.W(W)) u_reload (
        .reload_val (calc_val),
        .mode       (calc_mode),
        .start_val  (start_val),
        .low_val    (low_val)
    );

    tmr_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_stb  (load_stb),
        .load_val  (load_val),
        .load_mode (mode_sel),
        .tick      (tick),
        .gate_rise (gate_rise),
        .start_val (start_val),
        .low_val   (low_val),
        .calc_val  (calc_val),
        .calc_mode (calc_mode),
        .count_o   (count),
        .out_o     (out),
        .mode_o    (cur_mode)
    );

    // R2: a load is visible on count the next cycle (non-square modes)
    p_load_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && mode_sel != 3'd3 && mode_sel != 3'd7) |=>
            (count == $past(load_val)));

    // R10: level-gated modes hold while gate is low
    p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == M_TERM || cur_mode == M_SWSTB) && !gate && !load_stb) |=>
            $stable(count));

endmodule

// File: tb/tmr_channel_test.sv
module tmr_channel_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        gate = 1'b1;
    logic        load_stb = 1'b0;
    logic [15:0] load_val = '0;
    logic [2:0]  mode_sel = 3'd0;
    logic        out;
    logic [15:0] count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state: ticks since last load or restart
    int m_n = 65536;
    int m_d = 0;
    int m_md = 3;
    bit m_trig = 1;
    bit m_gprev = 1;

    logic        q_out[$];
    logic [15:0] q_cnt[$];
    string       q_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_channel #(.W(16), .CHAN_INDEX(0)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .gate     (gate),
        .load_stb (load_stb),
        .load_val (load_val),
        .mode_sel (mode_sel),
        .out      (out),
        .count    (count)
    );

    task automatic expect_now(output logic eo, output logic [15:0] ec);
        int r, h, eu, ed;
        case (m_md)
            0: begin
                eo = (m_d >= m_n);
                ec = 16'(m_n - m_d);
            end
            1, 5: begin
                if (!m_trig) begin
                    eo = 1'b1;
                    ec = 16'(m_n);
                end else begin
                    eo = (m_md == 1) ? (m_d >= m_n) : (m_d != m_n);
                    ec = 16'(m_n - m_d);
                end
            end
            2: begin
                r  = m_d % m_n;
                eo = !(m_d > 0 && r == 0);
                ec = 16'(m_n - r);
            end
            3: begin
                r  = m_d % m_n;
                h  = (m_n + 1) / 2;
                eu = m_n + (m_n % 2);
                ed = m_n - (m_n % 2);
                if (r < h) begin
                    eo = 1'b1;
                    ec = 16'(eu - 2 * r);
                end else begin
                    eo = 1'b0;
                    ec = 16'(ed - 2 * (r - h));
                end
            end
            default: begin
                eo = (m_d != m_n);
                ec = 16'(m_n - m_d);
            end
        endcase
    endtask

    // driver: one cycle of stimulus, then push the expected result
    task automatic cyc(input logic en, input logic g, input logic ld,
                       input logic [15:0] v, input logic [2:0] m, input string req);
        logic        eo;
        logic [15:0] ec;
        bit          rise;
        @(negedge clk);
        cnt_en = en; gate = g; load_stb = ld; load_val = v; mode_sel = m;
        @(posedge clk);
        rise    = g && !m_gprev;
        m_gprev = g;
        if (ld) begin
            m_n    = (v == 0) ? 65536 : int'(v);
            m_md   = (m >= 6) ? int'(m) - 4 : int'(m);
            m_d    = 0;
            m_trig = !(m_md == 1 || m_md == 5);
        end else if (rise && (m_md == 1 || m_md == 2 || m_md == 3 || m_md == 5)) begin
            m_d    = 0;
            m_trig = 1;
        end else if (en && m_trig && ((m_md == 0 || m_md == 4) ? g : 1'b1)) begin
            m_d = m_d + 1;
        end
        expect_now(eo, ec);
        q_out.push_back(eo);
        q_cnt.push_back(ec);
        q_req.push_back(req);
    endtask

    task automatic run(input int n, input logic en, input logic g, input string req);
        for (int i = 0; i < n; i++) cyc(en, g, 1'b0, 16'd0, 3'd0, req);
    endtask

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (q_out.size() > 0) begin
            logic        eo;
            logic [15:0] ec;
            string       rq;
            eo = q_out.pop_front();
            ec = q_cnt.pop_front();
            rq = q_req.pop_front();
            checks++;
            if (out !== eo || count !== ec) begin
                fails++;
                $display("FAIL %s t=%0t out=%b count=%h expected out=%b count=%h",
                         rq, $time, out, count, eo, ec);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        checks++;
        if (out !== 1'b1 || count !== 16'h0000) begin
            fails++;
            $display("FAIL R1 reset out=%b count=%h expected out=1 count=0000", out, count);
        end
        run(3, 1'b1, 1'b1, "R1");                       // no spurious restart
        // R3 and R12: terminal flag, enable gaps
        cyc(1'b1, 1'b1, 1'b1, 16'd5, 3'd0, "R3");
        run(8, 1'b1, 1'b1, "R3");
        run(4, 1'b0, 1'b1, "R12");
        cyc(1'b1, 1'b1, 1'b1, 16'd4, 3'd0, "R3");
        run(3, 1'b1, 1'b0, "R10");
        run(6, 1'b1, 1'b1, "R10");
        for (int i = 0; i < 8; i++) cyc(i % 3 != 0, 1'b1, 1'b0, 16'd0, 3'd0, "R12");
        // R2 and R11: zero load means 65536, then wrap
        cyc(1'b1, 1'b1, 1'b1, 16'd0, 3'd0, "R2");
        run(65540, 1'b1, 1'b1, "R11");
        // R4 and R9: one-shot
        cyc(1'b1, 1'b0, 1'b1, 16'd3, 3'd1, "R4");
        run(3, 1'b1, 1'b0, "R4");
        run(6, 1'b1, 1'b1, "R4");
        run(1, 1'b1, 1'b0, "R9");
        run(2, 1'b1, 1'b1, "R9");
        run(1, 1'b1, 1'b0, "R9");
        run(5, 1'b1, 1'b1, "R9");
        // R5: rate generator with enable gaps
        cyc(1'b1, 1'b1, 1'b1, 16'd4, 3'd2, "R5");
        for (int i = 0; i < 14; i++) cyc(i % 3 != 0, 1'b1, 1'b0, 16'd0, 3'd0, "R5");
        run(1, 1'b1, 1'b0, "R9");
        run(6, 1'b1, 1'b1, "R9");
        // R6 and R13: square wave, odd and even, aliases
        cyc(1'b1, 1'b1, 1'b1, 16'd5, 3'd3, "R6");
        run(14, 1'b1, 1'b1, "R6");
        cyc(1'b1, 1'b1, 1'b1, 16'd4, 3'd3, "R6");
        run(10, 1'b1, 1'b1, "R6");
        cyc(1'b1, 1'b1, 1'b1, 16'd7, 3'd7, "R13");
        run(16, 1'b1, 1'b1, "R13");
        cyc(1'b1, 1'b1, 1'b1, 16'd3, 3'd6, "R13");
        run(8, 1'b1, 1'b1, "R13");
        // R7: software strobe, gate level
        cyc(1'b1, 1'b1, 1'b1, 16'd3, 3'd4, "R7");
        run(12, 1'b1, 1'b1, "R7");
        cyc(1'b1, 1'b1, 1'b1, 16'd3, 3'd4, "R7");
        run(3, 1'b1, 1'b0, "R10");
        run(6, 1'b1, 1'b1, "R10");
        // R8: hardware strobe with re-arm
        cyc(1'b1, 1'b0, 1'b1, 16'd4, 3'd5, "R8");
        run(3, 1'b1, 1'b0, "R8");
        run(10, 1'b1, 1'b1, "R8");
        run(1, 1'b1, 1'b0, "R8");
        run(8, 1'b1, 1'b1, "R8");
        // R2: load wins over a coincident gate edge
        run(1, 1'b1, 1'b0, "R2");
        cyc(1'b1, 1'b1, 1'b1, 16'd3, 3'd2, "R2");
        run(5, 1'b1, 1'b1, "R2");
        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule